// File: doc/BRIEF.md
# Powerdown Sequencing Controller

This block steers a small processor core into and out of a low-power state. A request comes either from an active-low external pin or from a software-written force bit. Either one raises a non-maskable interrupt with a fixed vector address. The core then chooses its path. If it executes IDLE, the controller powers the core down: the acknowledge output goes high and the clock-out enable is held off. If it executes a return-from-interrupt, the request is dropped and the core keeps running.

A rising pin ends the powered-down phase. The controller then counts a parameterised number of start-up cycles, lowers the acknowledge output and re-enables clock-out. It pulses a resume-fetch strobe so that the core fetches the instruction after IDLE. When an extra start-up delay is selected, or when the wake-up comes from reset, the acknowledge falling marks only the restart of clock-out, and the resume strobe is delayed or not issued at all. Everything runs on a free-running reference clock. Clock gating is represented by an enable output.

Top module: `pwrdn_seq`

## Requirements
- R1: A falling edge of `pd_pin_n`, seen through a two-stage synchroniser, raises `nmi_req` on the third rising clock edge after the change, with `nmi_vector` equal to 0x002C. Holding the pin low raises no second request.
- R2: A one-cycle `force_wr` pulse raises the same request two edges later. The force bit clears itself when the pending request ends by powerdown or by abort, so a later IDLE while running does nothing.
- R3: While the request is pending, the outputs stay unchanged until `idle_stb`. The edge that samples `idle_stb` gives `ack`=1, `clkout_en`=0 and `nmi_req`=0.
- R4: An `rti_stb` during the pending phase returns the block to run on the next edge, with `nmi_req`=0, `ack`=0 and `clkout_en`=1. When `rti_stb` and `idle_stb` arrive in the same cycle, the return wins.
- R5: `idle_stb` and `rti_stb` have no effect while running without a request.
- R6: While powered down, `ack` stays 1 and `clkout_en` stays 0 whatever the input clock does. Wake-up needs the pin to be seen high after having been seen low since the request, so a forced powerdown lasts until a low-then-high pin pulse.
- R7: When the pin is seen high again and `delay_sel`=0, `ack` falls and `clkout_en` rises on edge 3+STARTUP_CYCLES after the pin change. `resume_fetch` is high in that same cycle.
- R8: With STARTUP_CYCLES=0, `ack` falls on the edge after the synchronised pin rise, which is edge 3 after the pin change.
- R9: With `delay_sel`=1 at the end of start-up, `ack` falls at the same point as in R7 but `resume_fetch` stays low. It pulses HOLD_CYCLES edges later.
- R10: Reset starts a boot phase of BOOT_CYCLES edges. During boot `nmi_req`=0, while `ack` and `clkout_en` hold fixed values that carry no meaning. Boot ends in run with `ack`=0 and `clkout_en`=1, and no `resume_fetch` pulse is issued, even when the reset hits a powered-down core.
- R11: `resume_fetch` is always a single-cycle pulse, issued only while `ack`=0 and `clkout_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pd_pin_n | input | 1 | asynchronous active-low powerdown request pin |
| force_wr | input | 1 | software write pulse that sets the force bit |
| idle_stb | input | 1 | core executed IDLE |
| rti_stb | input | 1 | core executed return-from-interrupt |
| delay_sel | input | 1 | extra start-up delay selected |
| nmi_req | output | 1 | non-maskable powerdown interrupt request |
| nmi_vector | output | 16 | vector address of that interrupt |
| ack | output | 1 | high while powered down or not yet restarted |
| clkout_en | output | 1 | clock-out toggling enable |
| resume_fetch | output | 1 | one-cycle strobe to fetch the instruction after IDLE |

## Verification
Inputs change on the falling clock edge and outputs are read on a falling edge, after a counted number of rising edges. A pin change reaches `nmi_req` or the wake logic after three edges: two synchroniser stages and one state register. A force write needs two edges, and a strobe acts on the first edge. A wake-up lands 3+STARTUP_CYCLES edges after the pin rises, plus HOLD_CYCLES more for the resume strobe when the delay is selected. Each check samples exactly at that point, and where it matters the check one edge earlier confirms that nothing has changed yet. A second instance with STARTUP_CYCLES=0 covers the zero-count case, and a negedge counter of `resume_fetch` pulses proves that none occurs after reset.

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter logic [7:0]  STARTUP_CYCLES = 8'd16,
  parameter logic [7:0]  HOLD_CYCLES    = 8'd4,
  parameter logic [7:0]  BOOT_CYCLES    = 8'd100,
  parameter logic [15:0] VEC_ADDR       = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pd_pin_n,
  input  logic        force_wr,
  input  logic        idle_stb,
  input  logic        rti_stb,
  input  logic        delay_sel,
  output logic        nmi_req,
  output logic [15:0] nmi_vector,
  output logic        ack,
  output logic        clkout_en,
  output logic        resume_fetch
);

  typedef enum logic [2:0] {BOOT, RUN, PEND, DOWN, START, HOLD} st_t;

  st_t        st;
  logic [1:0] sync_q;
  logic       prev_q, force_q, armed_q, rf_q;
  logic [7:0] cnt;

  wire pin_s   = sync_q[1];
  wire pd_fall = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pd_pin_n};
      prev_q <= pin_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= BOOT;
      cnt     <= '0;
      force_q <= 1'b0;
      armed_q <= 1'b0;
      rf_q    <= 1'b0;
    end else begin
      rf_q <= 1'b0;
      if (force_wr) force_q <= 1'b1;
      case (st)
        BOOT:
          if (cnt == BOOT_CYCLES - 8'd1) begin
            st  <= RUN;
            cnt <= '0;
          end else cnt <= cnt + 8'd1;
        RUN:
          if (pd_fall || force_q) begin
            st      <= PEND;
            armed_q <= pd_fall;
          end
        PEND:
          if (rti_stb) begin
            st      <= RUN;
            force_q <= 1'b0;
            armed_q <= 1'b0;
          end else if (idle_stb) begin
            st      <= DOWN;
            force_q <= 1'b0;
          end
        DOWN:
          if (!pin_s) armed_q <= 1'b1;
          else if (armed_q) begin
            armed_q <= 1'b0;
            cnt     <= '0;
            if (STARTUP_CYCLES != 8'd0) st <= START;
            else if (delay_sel) st <= HOLD;
            else begin
              st   <= RUN;
              rf_q <= 1'b1;
            end
          end
        START:
          if (cnt == STARTUP_CYCLES - 8'd1) begin
            cnt <= '0;
            if (delay_sel) st <= HOLD;
            else begin
              st   <= RUN;
              rf_q <= 1'b1;
            end
          end else cnt <= cnt + 8'd1;
        HOLD:
          if (cnt == HOLD_CYCLES - 8'd1) begin
            st   <= RUN;
            cnt  <= '0;
            rf_q <= 1'b1;
          end else cnt <= cnt + 8'd1;
        default: st <= BOOT;
      endcase
    end

  assign nmi_req      = (st == PEND);
  assign nmi_vector   = VEC_ADDR;
  assign ack          = st inside {BOOT, DOWN, START};
  assign clkout_en    = st inside {RUN, PEND, HOLD};
  assign resume_fetch = rf_q;

  a_r3_idle_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && idle_stb && !rti_stb) |=> (ack && !clkout_en && !nmi_req));

  a_r4_rti_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && rti_stb) |=> (!ack && clkout_en && !nmi_req));

  a_r6_stays_down: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DOWN && !pin_s) |=> (ack && !clkout_en));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resume_fetch |=> !resume_fetch);

  a_r11_fetch_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    resume_fetch |-> (!ack && clkout_en));

  a_r1_request_only_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(st == RUN));

endmodule

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic pin, frc, idl, rti;
    logic [7:0] wt;
    logic nmi, ack, clk, rf;
    logic [7:0] req;
  } vec_t;

  localparam vec_t TBL [0:21] = '{
    '{1'b0,1'b0,1'b0,1'b0, 8'd3,  1'b1,1'b0,1'b1,1'b0, 8'd1},  // R1 pin low raises request
    '{1'b0,1'b0,1'b0,1'b0, 8'd5,  1'b1,1'b0,1'b1,1'b0, 8'd3},  // R3 waits for IDLE
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,  1'b0,1'b1,1'b0,1'b0, 8'd3},  // R3 IDLE enters powerdown
    '{1'b0,1'b0,1'b0,1'b0, 8'd20, 1'b0,1'b1,1'b0,1'b0, 8'd6},  // R6 stays down
    '{1'b1,1'b0,1'b0,1'b0, 8'd18, 1'b0,1'b1,1'b0,1'b0, 8'd7},  // R7 not yet awake
    '{1'b1,1'b0,1'b0,1'b0, 8'd1,  1'b0,1'b0,1'b1,1'b1, 8'd7},  // R7 awake with resume
    '{1'b1,1'b0,1'b0,1'b0, 8'd1,  1'b0,1'b0,1'b1,1'b0, 8'd11}, // R11 one-cycle pulse
    '{1'b1,1'b0,1'b1,1'b0, 8'd2,  1'b0,1'b0,1'b1,1'b0, 8'd5},  // R5 IDLE ignored in run
    '{1'b1,1'b0,1'b0,1'b1, 8'd2,  1'b0,1'b0,1'b1,1'b0, 8'd5},  // R5 RTI ignored in run
    '{1'b0,1'b0,1'b0,1'b0, 8'd3,  1'b1,1'b0,1'b1,1'b0, 8'd1},  // R1 second request
    '{1'b0,1'b0,1'b0,1'b1, 8'd1,  1'b0,1'b0,1'b1,1'b0, 8'd4},  // R4 RTI abort
    '{1'b0,1'b0,1'b0,1'b0, 8'd10, 1'b0,1'b0,1'b1,1'b0, 8'd1},  // R1 held low, no repeat
    '{1'b1,1'b0,1'b0,1'b0, 8'd3,  1'b0,1'b0,1'b1,1'b0, 8'd1},  // R1 rise is not a request
    '{1'b1,1'b1,1'b0,1'b0, 8'd2,  1'b1,1'b0,1'b1,1'b0, 8'd2},  // R2 force request
    '{1'b1,1'b0,1'b1,1'b1, 8'd1,  1'b0,1'b0,1'b1,1'b0, 8'd4},  // R4 RTI beats IDLE
    '{1'b1,1'b0,1'b0,1'b0, 8'd3,  1'b0,1'b0,1'b1,1'b0, 8'd2},  // R2 force cleared by abort
    '{1'b1,1'b1,1'b0,1'b0, 8'd2,  1'b1,1'b0,1'b1,1'b0, 8'd2},  // R2 force again
    '{1'b1,1'b0,1'b1,1'b0, 8'd1,  1'b0,1'b1,1'b0,1'b0, 8'd2},  // R2 forced powerdown
    '{1'b1,1'b0,1'b0,1'b0, 8'd30, 1'b0,1'b1,1'b0,1'b0, 8'd6},  // R6 no pulse, stays down
    '{1'b0,1'b0,1'b0,1'b0, 8'd3,  1'b0,1'b1,1'b0,1'b0, 8'd6},  // R6 pin low arms wake
    '{1'b1,1'b0,1'b0,1'b0, 8'd19, 1'b0,1'b0,1'b1,1'b1, 8'd7},  // R7 wake after pulse
    '{1'b1,1'b0,1'b1,1'b0, 8'd2,  1'b0,1'b0,1'b1,1'b0, 8'd2}   // R2 force bit gone
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_pin_n = 1'b1, force_wr = 1'b0, idle_stb = 1'b0, rti_stb = 1'b0, delay_sel = 1'b0;
  logic nmi_req, ack, clkout_en, resume_fetch;
  logic [15:0] nmi_vector;
  logic z_nmi, z_ack, z_clk, z_rf;
  logic [15:0] z_vec;
  int n_chk = 0, n_fail = 0, rf_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_seq u0 (.clk(clk), .rst_n(rst_n), .pd_pin_n(pd_pin_n), .force_wr(force_wr),
    .idle_stb(idle_stb), .rti_stb(rti_stb), .delay_sel(delay_sel), .nmi_req(nmi_req),
    .nmi_vector(nmi_vector), .ack(ack), .clkout_en(clkout_en), .resume_fetch(resume_fetch));

  pwrdn_seq #(.STARTUP_CYCLES(8'd0)) u1 (.clk(clk), .rst_n(rst_n), .pd_pin_n(pd_pin_n),
    .force_wr(force_wr), .idle_stb(idle_stb), .rti_stb(rti_stb), .delay_sel(delay_sel),
    .nmi_req(z_nmi), .nmi_vector(z_vec), .ack(z_ack), .clkout_en(z_clk), .resume_fetch(z_rf));

  always @(negedge clk) if (resume_fetch) rf_seen++;

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic pin, input logic frc, input logic idl, input logic rti, input int wt);
    pd_pin_n = pin; force_wr = frc; idle_stb = idl; rti_stb = rti;
    for (int i = 0; i < wt; i++) begin
      @(posedge clk);
      #1 force_wr = 1'b0; idle_stb = 1'b0; rti_stb = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(10, "nmi_req in reset", {15'd0, nmi_req}, 16'd0);
    chk(10, "resume_fetch in reset", {15'd0, resume_fetch}, 16'd0);
    rst_n = 1'b1;
    repeat (102) @(negedge clk);
    chk(10, "ack after boot", {15'd0, ack}, 16'd0);
    chk(10, "clkout_en after boot", {15'd0, clkout_en}, 16'd1);
    chk(10, "no resume pulse after boot", rf_seen[15:0], 16'd0);

    for (int k = 0; k < 22; k++) begin
      apply(TBL[k].pin, TBL[k].frc, TBL[k].idl, TBL[k].rti, int'(TBL[k].wt));
      chk(int'(TBL[k].req), $sformatf("row %0d nmi_req", k), {15'd0, nmi_req}, {15'd0, TBL[k].nmi});
      chk(int'(TBL[k].req), $sformatf("row %0d ack", k), {15'd0, ack}, {15'd0, TBL[k].ack});
      chk(int'(TBL[k].req), $sformatf("row %0d clkout_en", k), {15'd0, clkout_en}, {15'd0, TBL[k].clk});
      chk(int'(TBL[k].req), $sformatf("row %0d resume_fetch", k), {15'd0, resume_fetch}, {15'd0, TBL[k].rf});
      if (TBL[k].nmi) chk(1, "vector", nmi_vector, 16'h002C);  // R1
    end

    // R8 zero start-up count on u1
    apply(1'b0, 1'b0, 1'b0, 1'b0, 3);
    chk(8, "u1 nmi_req", {15'd0, z_nmi}, 16'd1);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 2);
    chk(8, "u1 ack before wake", {15'd0, z_ack}, 16'd1);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1);
    chk(8, "u1 ack after wake", {15'd0, z_ack}, 16'd0);
    chk(8, "u1 resume_fetch", {15'd0, z_rf}, 16'd1);
    chk(8, "u0 ack still high", {15'd0, ack}, 16'd1);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 20);

    // R9 delayed resume
    delay_sel = 1'b1;
    apply(1'b0, 1'b0, 1'b0, 1'b0, 3);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 19);
    chk(9, "ack at wake with delay", {15'd0, ack}, 16'd0);
    chk(9, "clkout_en at wake with delay", {15'd0, clkout_en}, 16'd1);
    chk(9, "no resume at ack fall", {15'd0, resume_fetch}, 16'd0);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 3);
    chk(9, "resume not yet", {15'd0, resume_fetch}, 16'd0);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1);
    chk(9, "resume after hold", {15'd0, resume_fetch}, 16'd1);
    delay_sel = 1'b0;

    // R10 reset while powered down
    apply(1'b0, 1'b0, 1'b0, 1'b0, 3);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1);
    chk(10, "down before reset", {15'd0, ack}, 16'd1);
    rst_n = 1'b0; pd_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(10, "nmi_req in second reset", {15'd0, nmi_req}, 16'd0);
    rf_seen = 0;
    rst_n = 1'b1;
    repeat (102) @(negedge clk);
    chk(10, "ack after reset wake", {15'd0, ack}, 16'd0);
    chk(10, "clkout_en after reset wake", {15'd0, clkout_en}, 16'd1);
    chk(10, "no resume after reset wake", rf_seen[15:0], 16'd0);

    finish_run();
  end
endmodule